// File: doc/BRIEF.md
# Serial Program Bootstrap Loader

The loader brings a processor out of reset by fetching its program over an asynchronous serial line. While the boot-mode select holds the serial-boot code, the block receives a six-byte header and then the program image. The header gives the number of 24-bit program words and the address where loading starts. Each program word arrives as three bytes, which the block packs into one word and writes through a program-memory write port at consecutive addresses. Every accepted byte goes back out on the transmit line as an echo, so the host can confirm the link.

When the last word has been written, the block raises a one-cycle run-release pulse. The pulse carries the load start address as the entry point, and the operating mode then counts as cleared. The receiver and the transmitter are inside the block. Both are timed by an oversampling enable that ticks 16 times per bit. No other boot-mode code has any effect, and that includes the reserved code 3'b111.

Top module: `serial_boot_loader`

States of the sequencer:
- LD_OFF: waits for the mode select. It moves to LD_COUNT when the select equals 3'b110.
- LD_COUNT: collects the three count bytes, then moves to LD_ADDR.
- LD_ADDR: collects the three address bytes. It moves to LD_RUN when the count is zero, and to LD_DATA otherwise.
- LD_DATA: collects and writes words. It moves to LD_RUN once the last word is written.
- LD_RUN: lasts one cycle, during which the release pulse is high. It always moves to LD_DONE.
- LD_DONE: stays there until the next reset.

## Requirements
- R1: A character has 1 start bit (low), 8 data bits sent LSB first, and 1 stop bit (high), with no parity. Each bit lasts 16 `os_tick` enables, and each data bit is sampled near its middle.
- R2: A low pulse on `rxd` that is high again by the middle of the start bit is dropped. It produces no byte and no echo.
- R3: A character whose stop bit is low raises `frame_err` for one clock cycle. The byte is thrown away: it is not echoed and not counted toward the header or the image.
- R4: Each byte accepted while loading is sent back on `txd` in the same 8N1 format. The echo waits until the transmit holding register is empty.
- R5: The first three accepted bytes form the 24-bit word count, least significant byte first.
- R6: The next three accepted bytes form the 24-bit load start address, least significant byte first.
- R7: Each later group of three bytes is packed LSB first into a 24-bit word. The word is written with a one-cycle `mem_we` pulse, at the start address for the first word and one higher for each next word, with the address wrapping modulo 2^24.
- R8: In the cycle after the final write, `run_go` is high for exactly one cycle, and `run_entry` then equals the start address. After that no further write or echo happens until reset.
- R9: A word count of zero skips the data phase. `run_go` follows the address header directly, with no write at all.
- R10: Only boot mode 3'b110 starts the loader. Under any other code, including the reserved 3'b111, there is no echo, no write and no release.
- R11: During reset and just after it, `txd` is high and `mem_we`, `run_go` and `frame_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| boot_mode | input | 3 | Boot-mode select; 3'b110 enables serial load |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line carrying the echo |
| mem_we | output | 1 | Program-memory write strobe |
| mem_addr | output | 24 | Program-memory write address |
| mem_wdata | output | 24 | Program-memory write data |
| run_go | output | 1 | One-cycle release to execution |
| run_entry | output | 24 | Entry address, valid with run_go |
| frame_err | output | 1 | One-cycle flag for a low stop bit |

## Verification
A table of loads covers word counts of two, one, zero and three. The zero-count load separates the skip path from the normal data path. The three-word load starts at 0xFFFFFE, so its address wraps, and this shows whether the address counter is truly 24 bits wide. The word values mix high-byte and low-byte patterns, which exposes any byte-order or packing slip. Directed runs send a short start glitch, a character with a low stop bit, the reserved mode code and bytes after release. Together these show whether the receiver filters correctly and whether the loader starts and stops only when it should.

// File: rtl/boot_loader_pkg.sv
package boot_loader_pkg;
    typedef enum logic [2:0] {
        LD_OFF, LD_COUNT, LD_ADDR, LD_DATA, LD_RUN, LD_DONE
    } ld_state_t;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_BITS, RX_STOP
    } rx_state_t;
endpackage

// File: rtl/boot_uart_rx.sv
module boot_uart_rx #(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    output logic [DW-1:0] data,
    output logic          valid,
    output logic          ferr
);
    import boot_loader_pkg::*;
    localparam int CW = $clog2(OS);
    localparam int BW = $clog2(DW);

    rx_state_t     st;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bidx;
    logic [DW-1:0] sh;
    logic          s1, s2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            sh    <= '0;
            data  <= '0;
            valid <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            valid <= 1'b0;
            ferr  <= 1'b0;
            if (tick) begin
                unique case (st)
                    RX_IDLE: if (!s2) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                    RX_START: if (cnt == CW'(OS/2 - 1)) begin
                        cnt  <= '0;
                        bidx <= '0;
                        st   <= s2 ? RX_IDLE : RX_BITS;
                    end else cnt <= cnt + 1'b1;
                    RX_BITS: if (cnt == CW'(OS - 1)) begin
                        cnt <= '0;
                        sh  <= {s2, sh[DW-1:1]};
                        if (bidx == BW'(DW - 1)) st <= RX_STOP;
                        else bidx <= bidx + 1'b1;
                    end else cnt <= cnt + 1'b1;
                    RX_STOP: if (cnt == CW'(OS - 1)) begin
                        cnt <= '0;
                        st  <= RX_IDLE;
                        if (s2) begin
                            data  <= sh;
                            valid <= 1'b1;
                        end else ferr <= 1'b1;
                    end else cnt <= cnt + 1'b1;
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/boot_uart_tx.sv
module boot_uart_tx #(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic          ready,
    output logic          txd
);
    localparam int CW  = $clog2(OS);
    localparam int FW  = DW + 2;
    localparam int NBW = $clog2(FW);

    logic [DW-1:0]  hold;
    logic           hold_full;
    logic [FW-1:0]  sh;
    logic           busy;
    logic [CW-1:0]  cnt;
    logic [NBW-1:0] nb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            hold_full <= 1'b0;
            sh        <= '1;
            busy      <= 1'b0;
            cnt       <= '0;
            nb        <= '0;
        end else begin
            if (load) begin
                hold      <= din;
                hold_full <= 1'b1;
            end
            if (tick) begin
                if (!busy) begin
                    if (hold_full) begin
                        sh        <= {1'b1, hold, 1'b0};
                        busy      <= 1'b1;
                        cnt       <= '0;
                        nb        <= '0;
                        hold_full <= 1'b0;
                    end
                end else if (cnt == CW'(OS - 1)) begin
                    cnt <= '0;
                    sh  <= {1'b1, sh[FW-1:1]};
                    if (nb == NBW'(FW - 1)) busy <= 1'b0;
                    else nb <= nb + 1'b1;
                end else cnt <= cnt + 1'b1;
            end
        end
    end

    assign ready = !hold_full;
    assign txd   = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/boot_seq.sv
module boot_seq #(
    parameter int           AW       = 24,
    parameter int           WW       = 24,
    parameter int           MW       = 3,
    parameter logic [MW-1:0] MODE_SEL = 3'b110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] boot_mode,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          tx_ready,
    output logic          tx_load,
    output logic [7:0]    tx_byte,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    output logic          run_go,
    output logic [AW-1:0] run_entry
);
    import boot_loader_pkg::*;
    localparam int BPW = WW / 8;
    localparam int IW  = $clog2(BPW);

    ld_state_t     state, nxt;
    logic [IW-1:0] bidx;
    logic [WW-9:0] part;
    logic [WW-1:0] word, cnt_left;
    logic [AW-1:0] start_addr, wr_addr;
    logic          pend, active, word_done;

    assign active    = (state == LD_COUNT) || (state == LD_ADDR) || (state == LD_DATA);
    assign word_done = rx_valid && active && (bidx == IW'(BPW - 1));
    assign word      = {rx_data, part};

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LD_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LD_OFF:   if (boot_mode == MODE_SEL) nxt = LD_COUNT;
            LD_COUNT: if (word_done) nxt = LD_ADDR;
            LD_ADDR:  if (word_done) nxt = (cnt_left == '0) ? LD_RUN : LD_DATA;
            LD_DATA:  if (word_done && cnt_left == WW'(1)) nxt = LD_RUN;
            LD_RUN:   nxt = LD_DONE;
            LD_DONE:  nxt = LD_DONE;
            default:  nxt = LD_OFF;
        endcase
    end

    always_comb begin
        mem_we    = word_done && (state == LD_DATA);
        mem_addr  = wr_addr;
        mem_wdata = word;
        run_go    = (state == LD_RUN);
        run_entry = start_addr;
        tx_load   = pend && tx_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bidx       <= '0;
            part       <= '0;
            cnt_left   <= '0;
            start_addr <= '0;
            wr_addr    <= '0;
            pend       <= 1'b0;
            tx_byte    <= '0;
        end else begin
            if (rx_valid && active) begin
                pend    <= 1'b1;
                tx_byte <= rx_data;
                part    <= {rx_data, part[WW-9:8]};
                bidx    <= word_done ? '0 : bidx + 1'b1;
            end else if (tx_load) begin
                pend <= 1'b0;
            end
            if (word_done) begin
                unique case (state)
                    LD_COUNT: cnt_left <= word;
                    LD_ADDR: begin
                        start_addr <= word[AW-1:0];
                        wr_addr    <= word[AW-1:0];
                    end
                    LD_DATA: begin
                        wr_addr  <= wr_addr + AW'(1);
                        cnt_left <= cnt_left - WW'(1);
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader #(
    parameter int AW = 24,
    parameter int WW = 24,
    parameter int OS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic [2:0]    boot_mode,
    input  logic          rxd,
    output logic          txd,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    output logic          run_go,
    output logic [AW-1:0] run_entry,
    output logic          frame_err
);
    logic [7:0] rx_data, tx_byte;
    logic       rx_valid, tx_load, tx_ready;

    boot_uart_rx #(.OS(OS), .DW(8)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd),
        .data(rx_data), .valid(rx_valid), .ferr(frame_err)
    );

    boot_uart_tx #(.OS(OS), .DW(8)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .load(tx_load),
        .din(tx_byte), .ready(tx_ready), .txd(txd)
    );

    boot_seq #(.AW(AW), .WW(WW), .MW(3), .MODE_SEL(3'b110)) seq_i (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_ready(tx_ready),
        .tx_load(tx_load), .tx_byte(tx_byte), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .run_go(run_go), .run_entry(run_entry)
    );
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    boot_mode,
    input logic          txd,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          run_go,
    input logic          frame_err
);
    logic          seen, armed, ran;
    logic [AW-1:0] last_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen      <= 1'b0;
            armed     <= 1'b0;
            ran       <= 1'b0;
            last_addr <= '0;
        end else begin
            if (mem_we) begin
                seen      <= 1'b1;
                last_addr <= mem_addr;
            end
            if (boot_mode == 3'b110) armed <= 1'b1;
            if (run_go) ran <= 1'b1;
        end
    end

    assert_run_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run_go |=> !run_go);
    assert_run_not_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_go && mem_we));
    assert_no_write_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ran |-> !mem_we);
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && seen) |-> (mem_addr == last_addr + AW'(1)));
    assert_quiet_unarmed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (txd && !mem_we && !run_go));
    assert_ferr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);
endmodule

bind serial_boot_loader boot_loader_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .txd(txd),
    .mem_we(mem_we), .mem_addr(mem_addr), .run_go(run_go),
    .frame_err(frame_err)
);

// File: tb/serial_boot_loader_tb_top.sv
`timescale 1ns/1ps
module serial_boot_loader_tb_top;
    localparam int BITCLK = 64;   // 16 ticks x 4 clocks per tick

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        os_tick;
    logic [2:0]  boot_mode = 3'b000;
    logic        rxd = 1'b1;
    logic        txd, mem_we, run_go, frame_err;
    logic [23:0] mem_addr, mem_wdata, run_entry;
    logic [1:0]  div = '0;

    always #10 clk = ~clk;
    always @(posedge clk) div <= div + 2'd1;
    assign os_tick = (div == 2'd3);

    serial_boot_loader dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .boot_mode(boot_mode),
        .rxd(rxd), .txd(txd), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .run_go(run_go), .run_entry(run_entry),
        .frame_err(frame_err)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    logic [23:0] wr_a [64];
    logic [23:0] wr_d [64];
    int          wr_n = 0, run_n = 0, ferr_n = 0, echo_n = 0, sent_n = 0;
    logic [23:0] entry_seen;
    logic [7:0]  echo_b [64];
    logic [7:0]  sent_b [64];

    localparam logic [23:0] V_CNT [4] = '{24'd2, 24'd1, 24'd0, 24'd3};
    localparam logic [23:0] V_ADR [4] = '{24'h000100, 24'hABCDEF, 24'h123456, 24'hFFFFFE};
    localparam logic [23:0] V_W [4][3] = '{
        '{24'h123456, 24'hA5C3F0, 24'h000000},
        '{24'h800001, 24'h000000, 24'h000000},
        '{24'h000000, 24'h000000, 24'h000000},
        '{24'h000001, 24'hFFFFFF, 24'h5A5A5A}};

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we && wr_n < 64) begin
                wr_a[wr_n] = mem_addr;
                wr_d[wr_n] = mem_wdata;
                wr_n = wr_n + 1;
            end
            if (run_go) begin
                run_n = run_n + 1;
                entry_seen = run_entry;
            end
            if (frame_err) ferr_n = ferr_n + 1;
        end
    end

    initial begin
        logic [7:0] b;
        forever begin
            @(negedge txd);
            repeat (BITCLK + BITCLK/2) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                b[i] = txd;
                repeat (BITCLK) @(negedge clk);
            end
            if (echo_n < 64) echo_b[echo_n] = b;
            echo_n = echo_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] mode);
        rst_n = 1'b0;
        rxd = 1'b1;
        boot_mode = mode;
        repeat (5) @(negedge clk);
        wr_n = 0; run_n = 0; ferr_n = 0; echo_n = 0; sent_n = 0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BITCLK) @(negedge clk);
        end
        rxd = stop;
        repeat (BITCLK) @(negedge clk);
        rxd = 1'b1;
        if (stop && sent_n < 64) begin
            sent_b[sent_n] = b;
            sent_n = sent_n + 1;
        end
    endtask

    task automatic send_word(input logic [23:0] w);
        send_byte(w[7:0], 1'b1);
        send_byte(w[15:8], 1'b1);
        send_byte(w[23:16], 1'b1);
    endtask

    task automatic check_echo(input string req);
        chk(echo_n == sent_n, req, echo_n, sent_n);
        for (int i = 0; i < sent_n && i < echo_n; i++)
            chk(echo_b[i] == sent_b[i], req, echo_b[i], sent_b[i]);
    endtask

    initial begin
        do_reset(3'b110);
        // R11: reset state
        chk(txd == 1'b1, "R11 txd idle", txd, 1);
        chk(mem_we == 1'b0 && run_go == 1'b0 && frame_err == 1'b0,
            "R11 outputs low", {mem_we, run_go, frame_err}, 0);

        // Table of loads: R1 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < 4; v++) begin
            do_reset(3'b110);
            send_word(V_CNT[v]);
            send_word(V_ADR[v]);
            for (int k = 0; k < int'(V_CNT[v]); k++) send_word(V_W[v][k]);
            repeat (1000) @(negedge clk);
            chk(wr_n == int'(V_CNT[v]), "R5 word count", wr_n, V_CNT[v]);
            for (int k = 0; k < wr_n && k < 3; k++) begin
                chk(wr_a[k] == V_ADR[v] + 24'(k), "R6 R7 write address", wr_a[k], V_ADR[v] + 24'(k));
                chk(wr_d[k] == V_W[v][k], "R1 R7 write data", wr_d[k], V_W[v][k]);
            end
            chk(run_n == 1, "R8 R9 single release", run_n, 1);
            chk(entry_seen == V_ADR[v], "R8 entry address", entry_seen, V_ADR[v]);
            check_echo("R4 echo");
            // R8: bytes after release are ignored
            send_byte(8'h3C, 1'b1);
            repeat (1000) @(negedge clk);
            chk(echo_n == sent_n - 1, "R8 no echo after run", echo_n, sent_n - 1);
            chk(wr_n == int'(V_CNT[v]) && run_n == 1, "R8 quiet after run", wr_n, V_CNT[v]);
        end

        // R2 and R3: glitch and framing error do not enter the header
        do_reset(3'b110);
        send_byte(8'h77, 1'b0);
        repeat (200) @(negedge clk);
        chk(ferr_n == 1, "R3 frame_err flagged", ferr_n, 1);
        @(negedge clk);
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (800) @(negedge clk);
        chk(echo_n == 0, "R2 R3 nothing echoed", echo_n, 0);
        send_word(24'd1);
        send_word(24'h000010);
        send_word(24'h00AA55);
        repeat (1000) @(negedge clk);
        chk(wr_n == 1, "R3 R2 bad bytes not counted", wr_n, 1);
        chk(wr_n >= 1 && wr_a[0] == 24'h000010 && wr_d[0] == 24'h00AA55,
            "R3 load after error", wr_d[0], 24'h00AA55);
        chk(run_n == 1 && entry_seen == 24'h000010, "R8 release after error", entry_seen, 24'h10);
        check_echo("R4 echo after error");

        // R10: reserved and other modes do nothing
        for (int m = 0; m < 2; m++) begin
            do_reset(m == 0 ? 3'b111 : 3'b010);
            send_word(24'd1);
            send_word(24'h000005);
            send_word(24'h123123);
            repeat (1000) @(negedge clk);
            chk(echo_n == 0, "R10 no echo", echo_n, 0);
            chk(wr_n == 0 && run_n == 0, "R10 no write or run", wr_n + run_n, 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule